// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Burst Address Counters

This block is a two-port synchronous static memory of 18-bit words. Its depth is 4K words by default and 8K words when the address-width parameter is raised by one. Each port has its own clock and can read or write any word at the same time as the other port. On the rising edge of its clock, a port captures its chip enables, write strobe, counter strobes, address and write data into input registers. The captured values decide what happens in the cycle that follows.

Each port keeps a burst address counter. The counter can be cleared, loaded from the external address, or stepped by one on every edge. This lets a port stream through successive words without driving a new address each cycle. The address wraps from the top of the array back to zero.

A static mode input, shared by both ports, picks between two read paths. The flow-through path presents read data in the cycle right after the request is captured. The pipelined path adds one output register. In place of a tri-state bus, each port marks its read data with a valid flag.

Top module: `dual_burst_ram`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, both ports show dvalid 0 and dout 0, and both burst counters hold address 0.
- R2: A port is selected in a cycle when en_lo_n was 0 and en_hi was 1 at the capturing edge. A selected cycle with wr_n 0 stores din at the cycle's address. A selected cycle with wr_n 1 is a read. A write cycle shows dvalid 0.
- R3: With flow_mode 0 (pipelined), read data and dvalid 1 appear after the second rising edge counted from the edge that captured the read.
- R4: With flow_mode 1 (flow-through), read data and dvalid 1 appear after the edge that captured the read, one cycle earlier than in pipelined mode.
- R5: A cycle with en_lo_n 1 or en_hi 0 performs no write and shows dvalid 0. Whenever dvalid is 0, dout is 0. The counter strobes act even in a deselected cycle.
- R6: In pipelined mode, after a deselected cycle, the output is valid only after one selected read cycle has passed through the output register.
- R7: ld_n 0 (with clr_n 1) makes the captured addr the cycle's address, and the counter takes that value.
- R8: inc_n 0 (with clr_n 1 and ld_n 1) makes the cycle's address the counter value plus one, so a run of such cycles visits successive words.
- R9: Stepping from address DEPTH-1 gives address 0.
- R10: clr_n 0 makes the cycle's address 0 whatever ld_n and inc_n are. ld_n 0 wins over inc_n 0.
- R11: With clr_n, ld_n and inc_n all 1, the cycle reuses the counter's held address, and the addr input has no effect.
- R12: A read of a word that the other port writes in the same cycle returns the word's previous contents. A later read returns the new data.
- R13: Both ports carry out independent reads and writes in the same cycles, each on its own address. The only case left undefined is both ports writing one word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both ports |
| flow_mode | input | 1 | Static read path select: 1 flow-through, 0 pipelined |
| en_lo_n_a | input | 1 | Port A active-low chip enable |
| en_hi_a | input | 1 | Port A active-high chip enable |
| wr_n_a | input | 1 | Port A active-low write strobe |
| ld_n_a | input | 1 | Port A active-low counter load |
| inc_n_a | input | 1 | Port A active-low counter step |
| clr_n_a | input | 1 | Port A active-low counter clear |
| addr_a | input | ADDR_W | Port A external address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A read data |
| dvalid_a | output | 1 | Port A read data valid |
| en_lo_n_b | input | 1 | Port B active-low chip enable |
| en_hi_b | input | 1 | Port B active-high chip enable |
| wr_n_b | input | 1 | Port B active-low write strobe |
| ld_n_b | input | 1 | Port B active-low counter load |
| inc_n_b | input | 1 | Port B active-low counter step |
| clr_n_b | input | 1 | Port B active-low counter clear |
| addr_b | input | ADDR_W | Port B external address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B read data |
| dvalid_b | output | 1 | Port B read data valid |

## Verification
The hardest situation to reach from the ports is a burst that wraps from the top address to zero while the other port reads the same words in the same cycles. The old-versus-new data rule then has to hold at every step of the wrap. The stimulus sets this up by loading both counters near DEPTH-1 on the same edge and then stepping both together, first in pipelined mode and again in flow-through mode. Long runs of weighted random strobes then mix clears, loads, steps and deselects. The reference model marks any word that both ports write in the same cycle as unknown, so the bench never checks that case.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
   // Control bits after input registration; polarity already resolved
   typedef struct packed {
      logic sel;      // both chip enables active
      logic wr;       // write request
      logic clr;      // counter clear
      logic load;     // counter load from external address
      logic step;     // counter increment
   } port_ctl_t;

   localparam port_ctl_t CTL_IDLE = '{sel: 1'b0, wr: 1'b0, clr: 1'b0, load: 1'b0, step: 1'b0};
endpackage

// File: rtl/dbr_inreg.sv
module dbr_inreg
   import dbr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_lo_n,
   input  logic              en_hi,
   input  logic              wr_n,
   input  logic              ld_n,
   input  logic              inc_n,
   input  logic              clr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output port_ctl_t         ctl_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] din_q
);
   port_ctl_t ctl_d;

   always_comb begin
      ctl_d.sel  = ~en_lo_n & en_hi;
      ctl_d.wr   = ~wr_n;
      ctl_d.clr  = ~clr_n;
      ctl_d.load = ~ld_n;
      ctl_d.step = ~inc_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= CTL_IDLE;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         ctl_q  <= ctl_d;
         addr_q <= addr;
         din_q  <= din;
      end
   end
endmodule

// File: rtl/dbr_burst_ctr.sv
module dbr_burst_ctr
   import dbr_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_ctl_t         ctl_q,
   input  logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] cnt
);
   // Priority: clear, then load, then step, else hold
   always_comb begin
      if (ctl_q.clr)       eff_addr = '0;
      else if (ctl_q.load) eff_addr = addr_q;
      else if (ctl_q.step) eff_addr = cnt + 1'b1;
      else                 eff_addr = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= eff_addr;
   end
endmodule

// File: rtl/dbr_xor_array.sv
module dbr_xor_array #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 18,
   parameter int NPORT  = 2
) (
   input  logic [NPORT-1:0]             clk,
   input  logic [NPORT-1:0]             we,
   input  logic [NPORT-1:0][ADDR_W-1:0] addr,
   input  logic [NPORT-1:0][DATA_W-1:0] wdata,
   output logic [NPORT-1:0][DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   // bank_rd[g][h]: bank g read at port h's address
   logic [NPORT-1:0][NPORT-1:0][DATA_W-1:0] bank_rd;

   for (genvar g = 0; g < NPORT; g++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      logic [DATA_W-1:0] peer;

      for (genvar h = 0; h < NPORT; h++) begin : g_rd
         assign bank_rd[g][h] = mem[addr[h]];
      end

      always_comb begin
         peer = '0;
         for (int o = 0; o < NPORT; o++) begin
            if (o != g) peer = peer ^ bank_rd[o][g];
         end
      end

      // Each bank is written by one port's clock only
      always_ff @(posedge clk[g]) begin
         if (we[g]) mem[addr[g]] <= wdata[g] ^ peer;
      end
   end

   for (genvar h = 0; h < NPORT; h++) begin : g_port
      always_comb begin
         rdata[h] = '0;
         for (int g = 0; g < NPORT; g++) rdata[h] = rdata[h] ^ bank_rd[g][h];
      end
   end
endmodule

// File: rtl/dbr_outstage.sv
module dbr_outstage #(
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dout,
   output logic              dvalid
);
   logic [DATA_W-1:0] flow_d;
   logic [DATA_W-1:0] pipe_d;
   logic              pipe_v;

   assign flow_d = rd_en ? rdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_v <= 1'b0;
         pipe_d <= '0;
      end else begin
         pipe_v <= rd_en;
         pipe_d <= flow_d;
      end
   end

   assign dvalid = flow_mode ? rd_en  : pipe_v;
   assign dout   = flow_mode ? flow_d : pipe_d;
endmodule

// File: rtl/dual_burst_ram.sv
module dual_burst_ram
   import dbr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 18
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              en_lo_n_a,
   input  logic              en_hi_a,
   input  logic              wr_n_a,
   input  logic              ld_n_a,
   input  logic              inc_n_a,
   input  logic              clr_n_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] din_a,
   output logic [DATA_W-1:0] dout_a,
   output logic              dvalid_a,
   input  logic              en_lo_n_b,
   input  logic              en_hi_b,
   input  logic              wr_n_b,
   input  logic              ld_n_b,
   input  logic              inc_n_b,
   input  logic              clr_n_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] din_b,
   output logic [DATA_W-1:0] dout_b,
   output logic              dvalid_b
);
   localparam int NPORT = 2;

   if (ADDR_W != 12 && ADDR_W != 13) begin : g_bad_addr_w
      $error("dual_burst_ram: ADDR_W must be 12 (4K words) or 13 (8K words)");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dual_burst_ram: DATA_W must be positive");
   end

   logic [NPORT-1:0]             clk_w, en_lo_n_w, en_hi_w, wr_n_w, ld_n_w, inc_n_w, clr_n_w;
   logic [NPORT-1:0][ADDR_W-1:0] addr_w, addr_q, eff_w, cnt_w;
   logic [NPORT-1:0][DATA_W-1:0] din_w, din_q, rdat_w, dout_w;
   logic [NPORT-1:0]             we_w, rd_w, dvalid_w;
   port_ctl_t [NPORT-1:0]        ctl_q;

   assign clk_w     = {clk_b, clk_a};
   assign en_lo_n_w = {en_lo_n_b, en_lo_n_a};
   assign en_hi_w   = {en_hi_b, en_hi_a};
   assign wr_n_w    = {wr_n_b, wr_n_a};
   assign ld_n_w    = {ld_n_b, ld_n_a};
   assign inc_n_w   = {inc_n_b, inc_n_a};
   assign clr_n_w   = {clr_n_b, clr_n_a};
   assign addr_w    = {addr_b, addr_a};
   assign din_w     = {din_b, din_a};

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      dbr_inreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_inreg (
         .clk     (clk_w[p]),
         .rst_n   (rst_n),
         .en_lo_n (en_lo_n_w[p]),
         .en_hi   (en_hi_w[p]),
         .wr_n    (wr_n_w[p]),
         .ld_n    (ld_n_w[p]),
         .inc_n   (inc_n_w[p]),
         .clr_n   (clr_n_w[p]),
         .addr    (addr_w[p]),
         .din     (din_w[p]),
         .ctl_q   (ctl_q[p]),
         .addr_q  (addr_q[p]),
         .din_q   (din_q[p])
      );

      dbr_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
         .clk      (clk_w[p]),
         .rst_n    (rst_n),
         .ctl_q    (ctl_q[p]),
         .addr_q   (addr_q[p]),
         .eff_addr (eff_w[p]),
         .cnt      (cnt_w[p])
      );

      assign we_w[p] = ctl_q[p].sel &  ctl_q[p].wr;
      assign rd_w[p] = ctl_q[p].sel & ~ctl_q[p].wr;

      dbr_outstage #(.DATA_W(DATA_W)) u_out (
         .clk       (clk_w[p]),
         .rst_n     (rst_n),
         .flow_mode (flow_mode),
         .rd_en     (rd_w[p]),
         .rdata     (rdat_w[p]),
         .dout      (dout_w[p]),
         .dvalid    (dvalid_w[p])
      );
   end

   dbr_xor_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NPORT)) u_array (
      .clk   (clk_w),
      .we    (we_w),
      .addr  (eff_w),
      .wdata (din_q),
      .rdata (rdat_w)
   );

   assign dout_a   = dout_w[0];
   assign dout_b   = dout_w[1];
   assign dvalid_a = dvalid_w[0];
   assign dvalid_b = dvalid_w[1];
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flow_mode,
   input logic              ld_n,
   input logic              inc_n,
   input logic              clr_n,
   input logic [ADDR_W-1:0] addr,
   input logic [ADDR_W-1:0] cnt,
   input logic              sel_q,
   input logic [DATA_W-1:0] dout,
   input logic              dvalid
);
   assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dvalid |-> (dout == '0));

   assert_cnt_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> ##1 (cnt == '0));

   assert_cnt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !ld_n) |=> ##1 (cnt == $past(addr, 2)));

   assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && ld_n && !inc_n) |=> ##1 (cnt == $past(cnt) + 1'b1));

   assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && ld_n && inc_n) |=> ##1 $stable(cnt));

   assert_pipe_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flow_mode && !sel_q) |=> !dvalid);
endmodule

bind dual_burst_ram dbr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk_a (
   .clk       (clk_a),
   .rst_n     (rst_n),
   .flow_mode (flow_mode),
   .ld_n      (ld_n_a),
   .inc_n     (inc_n_a),
   .clr_n     (clr_n_a),
   .addr      (addr_a),
   .cnt       (cnt_w[0]),
   .sel_q     (ctl_q[0].sel),
   .dout      (dout_a),
   .dvalid    (dvalid_a)
);

bind dual_burst_ram dbr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk_b (
   .clk       (clk_b),
   .rst_n     (rst_n),
   .flow_mode (flow_mode),
   .ld_n      (ld_n_b),
   .inc_n     (inc_n_b),
   .clr_n     (clr_n_b),
   .addr      (addr_b),
   .cnt       (cnt_w[1]),
   .sel_q     (ctl_q[1].sel),
   .dout      (dout_b),
   .dvalid    (dvalid_b)
);

// File: tb/dual_burst_ram_tb.sv
module dual_burst_ram_tb;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 18;
   localparam int DEPTH  = 1 << ADDR_W;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic flow_mode;
   logic              en_lo_n [2];
   logic              en_hi   [2];
   logic              wr_n    [2];
   logic              ld_n    [2];
   logic              inc_n   [2];
   logic              clr_n   [2];
   logic [ADDR_W-1:0] addr    [2];
   logic [DATA_W-1:0] din     [2];
   logic [DATA_W-1:0] dout    [2];
   logic              dvalid  [2];

   dual_burst_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
      .clk_a(clk), .clk_b(clk), .rst_n(rst_n), .flow_mode(flow_mode),
      .en_lo_n_a(en_lo_n[0]), .en_hi_a(en_hi[0]), .wr_n_a(wr_n[0]), .ld_n_a(ld_n[0]),
      .inc_n_a(inc_n[0]), .clr_n_a(clr_n[0]), .addr_a(addr[0]), .din_a(din[0]),
      .dout_a(dout[0]), .dvalid_a(dvalid[0]),
      .en_lo_n_b(en_lo_n[1]), .en_hi_b(en_hi[1]), .wr_n_b(wr_n[1]), .ld_n_b(ld_n[1]),
      .inc_n_b(inc_n[1]), .clr_n_b(clr_n[1]), .addr_b(addr[1]), .din_b(din[1]),
      .dout_b(dout[1]), .dvalid_b(dvalid[1])
   );

   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;
   string cur_req = "R1";

   task automatic chk(input string req, input bit ok, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [DATA_W-1:0] mmem   [DEPTH];
   bit                mknown [DEPTH];
   int                mcnt   [2];
   bit                fv [2], pv [2], fk [2], pk [2];
   logic [DATA_W-1:0] fd [2], pd [2];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < 2; p++) begin
            mcnt[p] = 0; fv[p] = 0; pv[p] = 0; fk[p] = 1; pk[p] = 1; fd[p] = '0; pd[p] = '0;
         end
      end else begin
         int e [2];
         bit w [2];
         for (int p = 0; p < 2; p++) begin
            bit s;
            pv[p] = fv[p]; pd[p] = fd[p]; pk[p] = fk[p];
            s = !en_lo_n[p] && en_hi[p];
            if (!clr_n[p])     e[p] = 0;
            else if (!ld_n[p]) e[p] = int'(addr[p]);
            else if (!inc_n[p]) e[p] = (mcnt[p] + 1) % DEPTH;
            else               e[p] = mcnt[p];
            mcnt[p] = e[p];
            fv[p] = s && wr_n[p];
            fd[p] = fv[p] ? mmem[e[p]] : '0;
            fk[p] = fv[p] ? mknown[e[p]] : 1'b1;
            w[p]  = s && !wr_n[p];
         end
         if (w[0] && w[1] && e[0] == e[1]) begin
            mknown[e[0]] = 0;
         end else begin
            for (int p = 0; p < 2; p++) begin
               if (w[p]) begin mmem[e[p]] = din[p]; mknown[e[p]] = 1; end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int p = 0; p < 2; p++) begin
            bit ev, ek;
            logic [DATA_W-1:0] ed;
            ev = flow_mode ? fv[p] : pv[p];
            ed = flow_mode ? fd[p] : pd[p];
            ek = flow_mode ? fk[p] : pk[p];
            chk(cur_req, dvalid[p] === ev, $sformatf("port%0d dvalid", p), longint'(dvalid[p]), longint'(ev));
            if (ek)
               chk(cur_req, dout[p] === ed, $sformatf("port%0d dout", p), longint'(dout[p]), longint'(ed));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic setp(input int p, input bit eln, input bit eh, input bit wn,
                       input bit ln, input bit in_n, input bit cn, input int ad, input int dd);
      en_lo_n[p] = eln; en_hi[p] = eh; wr_n[p] = wn;
      ld_n[p] = ln; inc_n[p] = in_n; clr_n[p] = cn;
      addr[p] = ADDR_W'(ad); din[p] = DATA_W'(dd);
   endtask

   task automatic idle(input int p);       setp(p, 1, 0, 1, 1, 1, 1, 0, 0); endtask
   task automatic wr_ld(input int p, input int ad, input int dd); setp(p, 0, 1, 0, 0, 1, 1, ad, dd); endtask
   task automatic wr_st(input int p, input int dd); setp(p, 0, 1, 0, 1, 0, 1, 0, dd); endtask
   task automatic rd_ld(input int p, input int ad); setp(p, 0, 1, 1, 0, 1, 1, ad, 0); endtask
   task automatic rd_st(input int p);      setp(p, 0, 1, 1, 1, 0, 1, 0, 0); endtask

   task automatic tick(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic idle_both(input int n);
      idle(0); idle(1); tick(n);
   endtask

   task automatic directed();
      // R2 / R7 / R8: port A writes a burst, port B reads it back
      cur_req = "R2";
      wr_ld(0, 100, 18'h1000); idle(1); tick(1);
      for (int i = 1; i < 12; i++) begin wr_st(0, 18'h1000 + i); tick(1); end
      idle_both(2);
      cur_req = "R7";
      rd_ld(1, 100); tick(1);
      cur_req = "R8";
      for (int i = 0; i < 11; i++) begin rd_st(1); tick(1); end
      idle_both(3);
      // R13: simultaneous independent traffic
      cur_req = "R13";
      wr_ld(0, 400, 18'h2200); rd_ld(1, 104); tick(1);
      for (int i = 1; i < 6; i++) begin wr_st(0, 18'h2200 + i); rd_st(1); tick(1); end
      idle_both(3);
      // R12: same-cycle read of the word the other port writes
      cur_req = "R12";
      wr_ld(0, 105, 18'h3A5A5); rd_ld(1, 105); tick(1);
      idle(0); rd_ld(1, 105); tick(1);
      idle_both(3);
      // R9: wrap, with the other port reading the same words in the same cycles
      cur_req = "R9";
      wr_ld(0, DEPTH - 3, 18'h0A000); rd_ld(1, DEPTH - 3); tick(1);
      for (int i = 1; i < 6; i++) begin wr_st(0, 18'h0A000 + i); rd_st(1); tick(1); end
      idle_both(2);
      rd_ld(1, DEPTH - 3); tick(1);
      for (int i = 1; i < 6; i++) begin rd_st(1); tick(1); end
      idle_both(3);
      // R10: clear wins over load and step, load wins over step
      cur_req = "R10";
      setp(0, 0, 1, 0, 0, 0, 0, 700, 18'h0C1C1); idle(1); tick(1);
      setp(0, 0, 1, 0, 0, 0, 1, 701, 18'h0C2C2); tick(1);
      idle(0); tick(1);
      rd_ld(1, 0); tick(1); rd_ld(1, 701); tick(1); rd_ld(1, 702); tick(1);
      idle_both(3);
      // R11: held address, addr input ignored
      cur_req = "R11";
      wr_ld(0, 300, 18'h0B0B0); tick(1);
      setp(0, 0, 1, 0, 1, 1, 1, 999, 18'h0B0B1); tick(1);
      setp(0, 0, 1, 1, 1, 1, 1, 55, 0); tick(1);
      setp(0, 0, 1, 1, 1, 1, 1, 1234, 0); tick(1);
      idle(0); rd_ld(1, 999); tick(1); rd_ld(1, 300); tick(1);
      idle_both(3);
      // R5: deselected writes have no effect; counter strobes still act
      cur_req = "R5";
      setp(0, 1, 1, 0, 0, 1, 1, 100, 18'h3FFFF); tick(1);
      setp(0, 0, 0, 0, 1, 0, 1, 0, 18'h3FFFE); tick(1);
      setp(0, 1, 1, 1, 1, 0, 1, 0, 0); tick(1);
      rd_st(0); tick(1);
      idle(0); rd_ld(1, 100); tick(1); rd_ld(1, 101); tick(1); rd_ld(1, 102); tick(1);
      idle_both(3);
      // R6: alternate deselect and read
      cur_req = "R6";
      for (int i = 0; i < 4; i++) begin
         rd_ld(1, 100 + i); tick(1); idle(1); tick(1);
      end
      idle_both(3);
   endtask

   task automatic random_traffic(input int n);
      for (int c = 0; c < n; c++) begin
         for (int p = 0; p < 2; p++) begin
            setp(p, ($urandom % 8) == 0, ($urandom % 8) != 0, $urandom % 2,
                 ($urandom % 5) != 0, ($urandom % 3) == 0, ($urandom % 25) != 0,
                 int'($urandom % DEPTH), int'($urandom % (1 << DATA_W)));
         end
         tick(1);
      end
      idle_both(3);
   endtask

   initial begin
      idle(0); idle(1);
      flow_mode = 1'b0;
      rst_n = 1'b0;
      tick(3);
      for (int p = 0; p < 2; p++) begin
         chk("R1", dvalid[p] === 1'b0, $sformatf("reset port%0d dvalid", p), longint'(dvalid[p]), 0);
         chk("R1", dout[p] === '0, $sformatf("reset port%0d dout", p), longint'(dout[p]), 0);
      end
      rst_n = 1'b1;
      cur_req = "R1";
      tick(1);
      // counter reset value: a plain held read uses address 0
      wr_ld(0, 0, 18'h01234); tick(1); idle(0);
      setp(1, 0, 1, 1, 1, 1, 1, 77, 0); tick(1);
      idle_both(3);

      cur_req = "R3";
      directed();
      cur_req = "R3";
      random_traffic(2500);

      flow_mode = 1'b1;
      idle_both(3);
      cur_req = "R4";
      rd_ld(1, 100); tick(1); rd_st(1); tick(1);
      idle_both(2);
      directed();
      cur_req = "R4";
      random_traffic(2500);

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R13 actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule